// File: doc/BRIEF.md
# Reset-Cause Boot Entry and Serial Hook-Up Sequencer

This block runs once after every reset and decides whether the device starts its user application or enters a serial programming session. In the first cycle after reset it reads a reset-cause vector. Only a power-on cause takes the loader path. Any other cause, or no cause bit at all, launches user code at once.

On the loader path the sequencer offers the hook-up character 0xFC to a byte-wide UART transmitter and waits for the transmit handshake. It then listens on the byte-wide receiver for a reply, with a time-out measured in prescaled clock ticks. Before the baud rate is trusted, the reply is matched against every byte that 0xFC can turn into at a wrong rate. Once the rate is declared locked, only 0xFC is accepted. A valid reply moves the block into command mode. The command-mode output stays high until the quit byte arrives.

If the time-out expires, or after a quit, the block raises a one-cycle launch pulse and then parks until the next reset. The time-out is set by two inputs: the clocks per tick, and the number of ticks. At a 50 MHz clock, a prescale of 49999 and a count of 100 give about 100 ms.

States and transitions:
- SAMPLE_CAUSE goes to OFFER_HOOK when the power-on bit is set, and to LAUNCH otherwise.
- OFFER_HOOK goes to LISTEN when the transmit handshake completes.
- LISTEN goes to COMMAND on an accepted reply, and to LAUNCH when the time-out expires.
- COMMAND goes to LAUNCH on the quit byte.
- LAUNCH goes to PARKED.
- PARKED holds until the next reset.

Top module: `boot_entry_seq`

## Requirements
- R1: In the first cycle after reset release, `rst_cause[0]` (power-on) is read. If it is clear, `start_user` pulses in that first cycle and nothing is transmitted. If it is set, `tx_valid` rises in that first cycle.
- R2: On the loader path `tx_valid` presents `tx_data` = 0xFC. It stays high until the cycle in which `tx_ready` is high. Exactly one character is offered per reset.
- R3: With prescale P (`tick_presc`) and tick count N (`hook_ticks`), and no accepted reply, `start_user` pulses N*(P+1)+2 cycles after the transmit handshake cycle.
- R4: While `rate_locked` is low, a reply of 0xFF, 0xFE, 0xFC, 0xF8, 0xF0, 0xE0, 0xC0, 0x80 or 0x00 is accepted. `cmd_mode` rises in the cycle after the byte.
- R5: While `rate_locked` is high, only 0xFC is accepted. Any other byte is ignored.
- R6: A byte that is not accepted while listening has no effect. It does not restart or shift the time-out.
- R7: `cmd_mode` stays high until a received byte equals 0x51 (quit). Other bytes are ignored. After the quit byte, `cmd_mode` falls and `start_user` pulses in the next cycle.
- R8: `start_user` is high for exactly one cycle. After it, no transmit, command mode or further launch occurs until the next reset, whatever bytes arrive.
- R9: While `rst_n` is low, `tx_valid`, `cmd_mode` and `start_user` are low.
- R10: If an accepted reply arrives in the same cycle that the time-out expires, the reply wins and command mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_cause | input | CAUSE_W | Reset-cause flags; bit 0 = power-on |
| rate_locked | input | 1 | High once the serial rate is trusted |
| tick_presc | input | DIV_W | Clocks per time-out tick, minus one |
| hook_ticks | input | TICK_W | Time-out length in ticks |
| tx_data | output | 8 | Byte offered to the UART transmitter |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | One-cycle strobe for rx_data |
| cmd_mode | output | 1 | High while in command mode |
| start_user | output | 1 | One-cycle pulse to start user code |

## Verification
The first result after reset release is due in the first cycle: either the launch pulse or the hook-up offer. A reply byte driven in cycle c shows up as `cmd_mode` in cycle c+1. A time-out launch lands N*(P+1)+2 cycles after the transmit handshake, and the quit launch lands one cycle after the quit byte. The driver queues each expected event with the exact cycle number, counted from reset release. The monitor samples mid-cycle and rejects any event that arrives at another cycle, has the wrong kind, or was never queued.

// File: rtl/boot_entry_pkg.sv
package boot_entry_pkg;

    localparam logic [7:0] HOOK_CHAR = 8'hFC;
    localparam logic [7:0] QUIT_CHAR = 8'h51;

    // Typical time-out at a 50 MHz clock: 1 ms ticks, 100 of them
    localparam int unsigned TYP_PRESC = 49999;
    localparam int unsigned TYP_TICKS = 100;

    typedef enum logic [2:0] {
        SAMPLE_CAUSE,
        OFFER_HOOK,
        LISTEN,
        COMMAND,
        LAUNCH,
        PARKED
    } boot_state_e;

endpackage

// File: rtl/boot_hook_timer.sv
module boot_hook_timer #(
    parameter int DIV_W  = 16,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  presc,
    input  logic [TICK_W-1:0] limit,
    output logic              expired
);

    logic [DIV_W-1:0]  div_q;
    logic [TICK_W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_q <= '0;
        end else if (!run) begin
            div_q  <= '0;
            tick_q <= '0;
        end else if (div_q == presc) begin
            div_q <= '0;
            if (tick_q != limit)
                tick_q <= tick_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign expired = run && (tick_q == limit);

endmodule

// File: rtl/boot_reply_match.sv
module boot_reply_match (
    input  logic [7:0] rx_data,
    input  logic       rate_locked,
    output logic       accept
);
    import boot_entry_pkg::*;

    logic [7:0] inv;
    logic       alias_hit;

    // Leading ones followed by zeros: the inverse is a low-order run of ones
    always_comb begin
        inv       = ~rx_data;
        alias_hit = ((inv & (inv + 8'd1)) == 8'd0);
        accept    = rate_locked ? (rx_data == HOOK_CHAR) : alias_hit;
    end

endmodule

// File: rtl/boot_entry_seq.sv
module boot_entry_seq #(
    parameter int CAUSE_W = 8,
    parameter int DIV_W   = 16,
    parameter int TICK_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] rst_cause,
    input  logic               rate_locked,
    input  logic [DIV_W-1:0]   tick_presc,
    input  logic [TICK_W-1:0]  hook_ticks,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    input  logic [7:0]         rx_data,
    input  logic               rx_valid,
    output logic               cmd_mode,
    output logic               start_user
);
    import boot_entry_pkg::*;

    localparam int POR_BIT = 0;

    boot_state_e state_q, state_d;
    logic        reply_ok;
    logic        timed_out;
    logic        listening;

    assign listening = (state_q == LISTEN);

    boot_hook_timer #(
        .DIV_W (DIV_W),
        .TICK_W(TICK_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (listening),
        .presc  (tick_presc),
        .limit  (hook_ticks),
        .expired(timed_out)
    );

    boot_reply_match u_match (
        .rx_data    (rx_data),
        .rate_locked(rate_locked),
        .accept     (reply_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SAMPLE_CAUSE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SAMPLE_CAUSE: state_d = rst_cause[POR_BIT] ? OFFER_HOOK : LAUNCH;
            OFFER_HOOK:   if (tx_ready) state_d = LISTEN;
            LISTEN: begin
                if (rx_valid && reply_ok) state_d = COMMAND;
                else if (timed_out)       state_d = LAUNCH;
            end
            COMMAND:      if (rx_valid && rx_data == QUIT_CHAR) state_d = LAUNCH;
            LAUNCH:       state_d = PARKED;
            PARKED:       state_d = PARKED;
        endcase
    end

    always_comb begin
        tx_valid   = 1'b0;
        tx_data    = 8'h00;
        cmd_mode   = 1'b0;
        start_user = 1'b0;
        unique case (state_q)
            OFFER_HOOK: begin
                tx_valid = 1'b1;
                tx_data  = HOOK_CHAR;
            end
            COMMAND:      cmd_mode   = 1'b1;
            LAUNCH:       start_user = 1'b1;
            SAMPLE_CAUSE, LISTEN, PARKED: ;
        endcase
    end

endmodule

// File: rtl/boot_entry_seq_chk.sv
module boot_entry_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rate_locked,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       cmd_mode,
    input logic       start_user
);

    logic launched;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          launched <= 1'b0;
        else if (start_user) launched <= 1'b1;
    end

    assert_hook_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_data == 8'hFC);

    assert_offer_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid);

    assert_reply_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_mode) |-> $past(rx_valid));

    assert_locked_only_fc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_mode) && $past(rate_locked) |-> $past(rx_data) == 8'hFC);

    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mode && !(rx_valid && rx_data == 8'h51) |=> cmd_mode);

    assert_quit_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mode && rx_valid && rx_data == 8'h51 |=> start_user && !cmd_mode);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_user |=> !start_user);

    assert_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        launched |-> !start_user && !cmd_mode && !tx_valid);

endmodule

bind boot_entry_seq boot_entry_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_locked(rate_locked),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .cmd_mode   (cmd_mode),
    .start_user (start_user)
);

// File: tb/boot_entry_seq_test.sv
module boot_entry_seq_test;

    localparam int P = 4;
    localparam int N = 3;
    localparam int EV_TX = 0, EV_START = 1, EV_CMD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rst_cause = 8'h00;
    logic       rate_locked = 1'b0;
    logic [15:0] tick_presc = 16'(P);
    logic [7:0] hook_ticks = 8'(N);
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic       cmd_mode;
    logic       start_user;

    always #10 clk = ~clk;

    boot_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause),
        .rate_locked(rate_locked), .tick_presc(tick_presc),
        .hook_ticks(hook_ticks), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .cmd_mode(cmd_mode), .start_user(start_user)
    );

    typedef struct {
        int    kind;
        int    rel;
        string req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   base = 0;
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    logic prev_cmd = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int rel, input string req);
        q.push_back('{kind, rel, req});
    endtask

    task automatic observe(input int kind);
        int rel;
        exp_t e;
        rel = cyc - base;
        if (q.size() == 0) begin
            check(1'b0, "R8", $sformatf("unexpected event kind %0d at cycle", kind), rel, -1);
        end else begin
            e = q.pop_front();
            check(e.kind == kind, e.req, "event kind", kind, e.kind);
            check(e.rel == rel, e.req, "event cycle", rel, e.rel);
            if (kind == EV_TX)
                check(tx_data == 8'hFC, "R2", "hook-up byte", int'(tx_data), 'hFC);
        end
    endtask

    // Monitor: mid-cycle sampling, away from the active edge
    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            if (tx_valid && tx_ready) observe(EV_TX);
            if (start_user)           observe(EV_START);
            if (cmd_mode && !prev_cmd) observe(EV_CMD);
            prev_cmd = cmd_mode;
        end else begin
            prev_cmd = 1'b0;
        end
    end

    task automatic do_reset(input logic [7:0] cause, input logic locked, input logic ready);
        repeat (25) @(negedge clk);
        check(q.size() == 0, "R8", "expected events never seen", q.size(), 0);
        q.delete();
        rst_n       = 1'b0;
        rx_valid    = 1'b0;
        tx_ready    = ready;
        rst_cause   = cause;
        rate_locked = locked;
        repeat (3) @(negedge clk);
        check(!tx_valid && !cmd_mode && !start_user, "R9", "outputs in reset",
              int'({tx_valid, cmd_mode, start_user}), 0);
        rst_n = 1'b1;
        base  = cyc;
    endtask

    task automatic wait_rel(input int r);
        while (cyc - base < r) @(negedge clk);
    endtask

    task automatic send_at(input int r, input logic [7:0] b);
        wait_rel(r);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        // R1: non-power-on cause launches at once; R8: later bytes ignored
        do_reset(8'h02, 1'b0, 1'b1);
        expect_ev(EV_START, 1, "R1");
        send_at(4, 8'hFC);
        send_at(6, 8'h00);

        // R3: no reply, time-out launch; R8 afterwards
        do_reset(8'h01, 1'b0, 1'b1);
        expect_ev(EV_TX, 1, "R1");
        expect_ev(EV_START, 1 + N * (P + 1) + 2, "R3");
        send_at(25, 8'hFC);

        // R2: offer held while transmitter busy; R4 alias reply; R7 quit
        do_reset(8'h81, 1'b0, 1'b0);
        wait_rel(2);
        #5;
        check(tx_valid == 1'b1, "R2", "offer held while not ready", int'(tx_valid), 1);
        check(tx_data == 8'hFC, "R2", "offered byte", int'(tx_data), 'hFC);
        expect_ev(EV_TX, 3, "R2");
        wait_rel(3);
        tx_ready = 1'b1;
        expect_ev(EV_CMD, 7, "R4");
        send_at(6, 8'h80);
        send_at(9, 8'h49);
        send_at(11, 8'hFC);
        wait_rel(12);
        #5;
        check(cmd_mode == 1'b1, "R7", "command mode kept on other bytes", int'(cmd_mode), 1);
        expect_ev(EV_START, 14, "R7");
        send_at(13, 8'h51);

        // R5: locked rate accepts only 0xFC
        do_reset(8'h01, 1'b1, 1'b1);
        expect_ev(EV_TX, 1, "R1");
        send_at(4, 8'hF0);
        send_at(6, 8'h00);
        expect_ev(EV_CMD, 9, "R5");
        send_at(8, 8'hFC);
        expect_ev(EV_START, 11, "R7");
        send_at(10, 8'h51);

        // R6: rejected bytes do not restart the time-out
        do_reset(8'h01, 1'b0, 1'b1);
        expect_ev(EV_TX, 1, "R1");
        expect_ev(EV_START, 1 + N * (P + 1) + 2, "R6");
        send_at(6, 8'h55);
        send_at(12, 8'h7F);

        // R10: reply in the expiry cycle wins
        do_reset(8'h01, 1'b0, 1'b1);
        expect_ev(EV_TX, 1, "R1");
        expect_ev(EV_CMD, 1 + N * (P + 1) + 2, "R10");
        send_at(1 + N * (P + 1) + 1, 8'h00);
        expect_ev(EV_START, 21, "R7");
        send_at(20, 8'h51);

        // R4: every rate-mismatch image of 0xFC is accepted
        for (int k = 0; k <= 8; k++) begin
            logic [7:0] b;
            b = 8'(8'hFF << k);
            do_reset(8'h01, 1'b0, 1'b1);
            expect_ev(EV_TX, 1, "R1");
            expect_ev(EV_CMD, 5, "R4");
            send_at(4, b);
            expect_ev(EV_START, 7, "R7");
            send_at(6, 8'h51);
        end

        repeat (25) @(negedge clk);
        check(q.size() == 0, "R8", "expected events never seen", q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8: watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule